// File: doc/BRIEF.md
# Dual Configurable Decade Divider

The block holds two identical decade counters, A and B. Each decade is split into a divide-by-two stage, which drives bit 0 of its digit, and a divide-by-five stage, which drives bits 3..1. Each stage has its own count pin. Per decade, a configuration input picks one of two internal chainings:

- **BCD order:** the digit reads 0 to 9 in binary-coded decimal.
- **Bi-quinary order:** bit 0 becomes a symmetric divide-by-ten square wave.

A cascade input lets decade A's final output drive decade B, giving a divide-by-100 path. Other division ratios come from wiring digit bits back to the count pins outside the block.

Everything runs on one system clock. Count pins pass through synchronizer flops, and a stage advances when it detects a falling edge on its input. Internal links between stages use the same falling-edge detection, each without a synchronizer. So a change ripples through the chain one clock per link, and no derived clocks are needed. Each decade has its own clear input. The clear takes effect at once and is released on the clock.

Top module: `dual_decade_divider`

## Requirements
- R1: A stage advances only on a falling edge of its count input. A rising edge or a steady level leaves the digit unchanged.
- R2: The divide-by-five stage counts 0,1,2,3,4,0,... in binary on digit bits 3..1. Bit 3 is high only at count 4.
- R3: With order input 0 (BCD), `half_in` feeds bit 0 and a falling bit 0 feeds the divide-by-five stage. The digit then counts 0..9 in binary, one step per `half_in` fall, and wraps from 9 to 0.
- R4: With order input 1 (bi-quinary), `fifth_in` feeds the divide-by-five stage and a falling bit 3 toggles bit 0. Bit 0 then divides `fifth_in` by ten with a 50 % duty cycle.
- R5: The count pin a decade does not use in its order has no effect: `fifth_in` in BCD order, `half_in` in bi-quinary order.
- R6: A high clear forces that decade's four digit bits to 0 with no clock edge and holds them there. Count pin falls that arrive while the clear or its two-cycle release is in effect are dropped. Counting then resumes from 0.
- R7: The two clears are independent. With the cascade off, clearing one decade leaves the other digit unchanged. Both clears together zero all eight bits.
- R8: With `cascade_b` = 1, decade B's own in-use pin is ignored. Decade B is then fed instead by decade A's final output: bit 3 in BCD order, bit 0 in bi-quinary order. That output falls once per ten A input falls, including a fall caused by clearing A while B is not cleared.
- R9: A digit bit driven from a pin changes on the third rising clock edge after the pin falls. Each internal link between stages adds one more clock.
- R10: Overall ratios of 2, 4, 5, 10, 20, 25, 50 and 100 are reached by selecting a digit bit, by the cascade, or by looping an A digit bit to a B count pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_a | input | 1 | Asynchronous active-high clear, decade A |
| half_in_a | input | 1 | Count pin of A's divide-by-two stage |
| fifth_in_a | input | 1 | Count pin of A's divide-by-five stage |
| order_a | input | 1 | A chaining: 0 BCD, 1 bi-quinary |
| clr_b | input | 1 | Asynchronous active-high clear, decade B |
| half_in_b | input | 1 | Count pin of B's divide-by-two stage |
| fifth_in_b | input | 1 | Count pin of B's divide-by-five stage |
| order_b | input | 1 | B chaining: 0 BCD, 1 bi-quinary |
| cascade_b | input | 1 | 1: A's final output replaces B's in-use pin |
| digit_a | output | 4 | Decade A state, bit 0 from the divide-by-two stage |
| digit_b | output | 4 | Decade B state, bit 0 from the divide-by-two stage |

## Verification
The clear and a count edge can land in the same cycle. The bench provokes this in three ways:

- It drops a count pin one cycle before a clear, while the edge is still inside the synchronizer.
- It drops a pin one cycle after the clear is removed, while the release is still pending.
- It clears decade A while the output feeding decade B is high, so that the clear itself makes an edge.

In the first two cases the dropped edge must not count. In the third, the clear-induced fall must advance decade B exactly once. A stepping reference model judges all of these, together with random pulse and clear traffic.

// File: rtl/ddd_pkg.sv
package ddd_pkg;
   localparam int unsigned DIGIT_W   = 4;
   localparam int unsigned QUINARY_W = DIGIT_W - 1;
   localparam logic [QUINARY_W-1:0] QUINARY_TOP = QUINARY_W'(4);

   typedef enum logic {ORDER_BCD = 1'b0, ORDER_BIQUINARY = 1'b1} order_e;
   typedef logic [DIGIT_W-1:0] digit_t;

   function automatic logic [QUINARY_W-1:0] quinary_next(input logic [QUINARY_W-1:0] cur);
      return (cur >= QUINARY_TOP) ? '0 : cur + 1'b1;
   endfunction
endpackage

// File: rtl/ddd_rst_gen.sv
module ddd_rst_gen #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr,
   output logic rst
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ddd_rst_gen: STAGES must be at least 2");
   end

   logic [STAGES-1:0] hold;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) hold <= '1;
      else     hold <= {hold[STAGES-2:0], 1'b0};
   end

   assign rst = hold[STAGES-1];
endmodule

// File: rtl/ddd_fall_detect.sv
module ddd_fall_detect #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic fall
);
   logic level;
   logic prev;

   if (STAGES == 0) begin : g_direct
      assign level = din;
   end else begin : g_sync
      logic [STAGES-1:0] sr;
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or posedge rst) begin
               if (rst) sr[0] <= 1'b0;
               else     sr[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or posedge rst) begin
               if (rst) sr[i] <= 1'b0;
               else     sr[i] <= sr[i-1];
            end
         end
      end
      assign level = sr[STAGES-1];
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) prev <= 1'b0;
      else     prev <= level;
   end

   assign fall = prev & ~level;
endmodule

// File: rtl/ddd_decade.sv
module ddd_decade
   import ddd_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  order_e order,
   input  logic   half_tick,
   input  logic   fifth_tick,
   output digit_t digit,
   output logic   carry
);
   logic                 half_q;
   logic [QUINARY_W-1:0] fifth_q;
   logic                 half_fall;
   logic                 top_fall;
   logic                 adv_half;
   logic                 adv_fifth;

   ddd_fall_detect #(.STAGES(0)) u_half_link (
      .clk(clk), .rst(rst), .din(half_q), .fall(half_fall)
   );

   ddd_fall_detect #(.STAGES(0)) u_top_link (
      .clk(clk), .rst(rst), .din(fifth_q[QUINARY_W-1]), .fall(top_fall)
   );

   always_comb begin
      if (order == ORDER_BCD) begin
         adv_half  = half_tick;
         adv_fifth = half_fall;
      end else begin
         adv_half  = top_fall;
         adv_fifth = fifth_tick;
      end
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)           half_q <= 1'b0;
      else if (adv_half) half_q <= ~half_q;
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst)            fifth_q <= '0;
      else if (adv_fifth) fifth_q <= quinary_next(fifth_q);
   end

   assign digit = {fifth_q, half_q};
   assign carry = (order == ORDER_BCD) ? fifth_q[QUINARY_W-1] : half_q;
endmodule

// File: rtl/dual_decade_divider.sv
module dual_decade_divider
   import ddd_pkg::*;
#(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned RELEASE_STAGES = 2
) (
   input  logic       clk,
   input  logic       clr_a,
   input  logic       half_in_a,
   input  logic       fifth_in_a,
   input  logic       order_a,
   input  logic       clr_b,
   input  logic       half_in_b,
   input  logic       fifth_in_b,
   input  logic       order_b,
   input  logic       cascade_b,
   output logic [3:0] digit_a,
   output logic [3:0] digit_b
);
   localparam int unsigned NUM_DECADES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dual_decade_divider: SYNC_STAGES must be at least 2");
   end
   if (DIGIT_W != 4) begin : g_bad_width
      $error("dual_decade_divider: decade digit must be four bits");
   end

   logic [NUM_DECADES-1:0] clr_v, half_v, fifth_v, order_v;
   logic [NUM_DECADES-1:0] rst_v, carry_v, pin_half_fall, pin_fifth_fall;
   logic [NUM_DECADES-1:0] half_tick_v, fifth_tick_v;
   digit_t                 digit_v [NUM_DECADES];

   assign clr_v   = {clr_b, clr_a};
   assign half_v  = {half_in_b, half_in_a};
   assign fifth_v = {fifth_in_b, fifth_in_a};
   assign order_v = {order_b, order_a};

   for (genvar d = 0; d < NUM_DECADES; d++) begin : g_decade
      ddd_rst_gen #(.STAGES(RELEASE_STAGES)) u_rst (
         .clk(clk), .clr(clr_v[d]), .rst(rst_v[d])
      );

      ddd_fall_detect #(.STAGES(SYNC_STAGES)) u_half_pin (
         .clk(clk), .rst(rst_v[d]), .din(half_v[d]), .fall(pin_half_fall[d])
      );

      ddd_fall_detect #(.STAGES(SYNC_STAGES)) u_fifth_pin (
         .clk(clk), .rst(rst_v[d]), .din(fifth_v[d]), .fall(pin_fifth_fall[d])
      );

      if (d == 0) begin : g_head
         assign half_tick_v[d]  = pin_half_fall[d];
         assign fifth_tick_v[d] = pin_fifth_fall[d];
      end else begin : g_tail
         logic chain_fall;
         ddd_fall_detect #(.STAGES(0)) u_chain (
            .clk(clk), .rst(rst_v[d]), .din(carry_v[d-1]), .fall(chain_fall)
         );
         assign half_tick_v[d]  = cascade_b ? (~order_v[d] & chain_fall) : pin_half_fall[d];
         assign fifth_tick_v[d] = cascade_b ? ( order_v[d] & chain_fall) : pin_fifth_fall[d];
      end

      ddd_decade u_decade (
         .clk       (clk),
         .rst       (rst_v[d]),
         .order     (order_e'(order_v[d])),
         .half_tick (half_tick_v[d]),
         .fifth_tick(fifth_tick_v[d]),
         .digit     (digit_v[d]),
         .carry     (carry_v[d])
      );
   end

   assign digit_a = digit_v[0];
   assign digit_b = digit_v[1];
endmodule

// File: rtl/dual_decade_divider_chk.sv
module dual_decade_divider_chk (
   input logic       clk,
   input logic       clr_a,
   input logic       clr_b,
   input logic       order_a,
   input logic       order_b,
   input logic [3:0] digit_a,
   input logic [3:0] digit_b
);
   assert_quinary_range_R2_a: assert property (@(posedge clk) disable iff (clr_a)
      digit_a[3:1] <= 3'd4);
   assert_quinary_range_R2_b: assert property (@(posedge clk) disable iff (clr_b)
      digit_b[3:1] <= 3'd4);

   assert_quinary_step_R2_a: assert property (@(posedge clk) disable iff (clr_a)
      !$stable(digit_a[3:1]) |->
      digit_a[3:1] == (($past(digit_a[3:1]) == 3'd4) ? 3'd0 : $past(digit_a[3:1]) + 3'd1));
   assert_quinary_step_R2_b: assert property (@(posedge clk) disable iff (clr_b)
      !$stable(digit_b[3:1]) |->
      digit_b[3:1] == (($past(digit_b[3:1]) == 3'd4) ? 3'd0 : $past(digit_b[3:1]) + 3'd1));

   assert_bcd_link_R3_a: assert property (@(posedge clk) disable iff (clr_a)
      (!order_a && $fell(digit_a[0])) |=>
      digit_a[3:1] == (($past(digit_a[3:1]) == 3'd4) ? 3'd0 : $past(digit_a[3:1]) + 3'd1));
   assert_bcd_link_R3_b: assert property (@(posedge clk) disable iff (clr_b)
      (!order_b && $fell(digit_b[0])) |=>
      digit_b[3:1] == (($past(digit_b[3:1]) == 3'd4) ? 3'd0 : $past(digit_b[3:1]) + 3'd1));

   assert_biq_link_R4_a: assert property (@(posedge clk) disable iff (clr_a)
      (order_a && $fell(digit_a[3])) |=> digit_a[0] != $past(digit_a[0]));
   assert_biq_link_R4_b: assert property (@(posedge clk) disable iff (clr_b)
      (order_b && $fell(digit_b[3])) |=> digit_b[0] != $past(digit_b[0]));

   always @(posedge clk) begin
      if (clr_a) assert_async_clear_R6_a: assert (digit_a == 4'd0);
      if (clr_b) assert_async_clear_R6_b: assert (digit_b == 4'd0);
   end
endmodule

bind dual_decade_divider dual_decade_divider_chk u_chk (
   .clk(clk), .clr_a(clr_a), .clr_b(clr_b), .order_a(order_a), .order_b(order_b),
   .digit_a(digit_a), .digit_b(digit_b)
);

// File: tb/dual_decade_divider_test.sv
module dual_decade_divider_test;
   logic clk = 1'b0;
   logic clr_a = 1'b1, clr_b = 1'b1;
   logic ha = 1'b0, fa = 1'b0, hb_d = 1'b0, fb_d = 1'b0;
   logic oa = 1'b0, ob = 1'b0, casc = 1'b0;
   int   route = 0;
   int   lbit = 0;
   logic hb, fb;
   logic [3:0] digit_a, digit_b;
   int   n_chk = 0, n_fail = 0;
   logic [3:0] ma, mb;

   always #2 clk = ~clk;

   assign hb = (route == 2 && !ob) ? digit_a[lbit] : hb_d;
   assign fb = (route == 2 &&  ob) ? digit_a[lbit] : fb_d;

   dual_decade_divider uut (
      .clk(clk), .clr_a(clr_a), .half_in_a(ha), .fifth_in_a(fa), .order_a(oa),
      .clr_b(clr_b), .half_in_b(hb), .fifth_in_b(fb), .order_b(ob),
      .cascade_b(casc), .digit_a(digit_a), .digit_b(digit_b)
   );

   function automatic logic [3:0] step(input logic ord, input logic [3:0] v);
      logic [2:0] c;
      logic       b;
      if (!ord) return (v == 4'd9) ? 4'd0 : v + 4'd1;
      c = v[3:1];
      b = v[0];
      if (c == 3'd4) begin c = 3'd0; b = ~b; end
      else c = c + 3'd1;
      return {c, b};
   endfunction

   function automatic logic fin(input logic ord, input logic [3:0] v);
      return ord ? v[0] : v[3];
   endfunction

   task automatic check(input string tag, input string what, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic configure(input logic a_ord, input logic b_ord, input int rt, input int lb);
      @(negedge clk);
      clr_a = 1'b1; clr_b = 1'b1;
      ha = 0; fa = 0; hb_d = 0; fb_d = 0;
      oa = a_ord; ob = b_ord; route = rt; lbit = lb; casc = (rt == 1);
      tick(3);
      clr_a = 1'b0; clr_b = 1'b0;
      tick(6);
      ma = 4'd0; mb = 4'd0;
   endtask

   task automatic pulse(input logic p_ha, input logic p_fa, input logic p_hb, input logic p_fb);
      ha = p_ha; fa = p_fa; hb_d = p_hb; fb_d = p_fb;
      tick(4);
      ha = 0; fa = 0; hb_d = 0; fb_d = 0;
      tick(12);
   endtask

   task automatic ratio_run(input logic a_ord, input logic b_ord, input int rt, input int lb,
                            input bit use_b, input int obit, input int ratio);
      int   falls;
      logic prev, now;
      configure(a_ord, b_ord, rt, lb);
      falls = 0;
      prev  = 1'b0;
      for (int k = 0; k < 200; k++) begin
         pulse(!a_ord, a_ord, 1'b0, 1'b0);
         now = use_b ? digit_b[obit] : digit_a[obit];
         if (prev && !now) falls++;
         prev = now;
      end
      check("R10", $sformatf("falls for ratio %0d", ratio), 4'(falls), 4'(200 / ratio));
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [3:0] old_a;
      int highs;
      void'($urandom(32'd7741));
      tick(3);
      check("R6", "reset state A", digit_a, 4'd0);
      check("R6", "reset state B", digit_b, 4'd0);

      // R9 and R1: latency and rising edge immunity
      configure(1'b0, 1'b0, 0, 0);
      ha = 1'b1; tick(6);
      check("R1", "rising edge ignored", digit_a, 4'd0);
      ha = 1'b0;
      repeat (2) @(posedge clk); #1;
      check("R9", "unchanged after two edges", digit_a, 4'd0);
      @(posedge clk); #1;
      check("R9", "pin stage on third edge", digit_a, 4'd1);
      tick(10);
      ha = 1'b1; tick(4); ha = 1'b0;
      repeat (3) @(posedge clk); #1;
      check("R9", "bit 0 fell, quinary pending", digit_a, 4'd0);
      @(posedge clk); #1;
      check("R9", "link adds one edge", digit_a, 4'd2);
      tick(10);

      // R5: unused pins
      for (int k = 0; k < 3; k++) pulse(1'b0, 1'b1, 1'b0, 1'b0);
      check("R5", "fifth pin ignored in BCD", digit_a, 4'd2);
      configure(1'b1, 1'b0, 0, 0);
      for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, 1'b0, 1'b0);
      check("R5", "half pin ignored in bi-quinary", digit_a, 4'd0);

      // R4: duty of bit 0 in bi-quinary order
      highs = 0;
      for (int k = 0; k < 20; k++) begin
         pulse(1'b0, 1'b1, 1'b0, 1'b0);
         if (digit_a[0]) highs++;
      end
      check("R4", "bit 0 high steps of 20", 4'(highs), 4'd10);

      // R6: edge in flight when the clear arrives
      configure(1'b0, 1'b0, 0, 0);
      ha = 1'b1; tick(4); ha = 1'b0;
      tick(1);
      clr_a = 1'b1; tick(3); clr_a = 1'b0; tick(10);
      check("R6", "edge in synchronizer dropped", digit_a, 4'd0);
      // R6: edge during pending release
      ha = 1'b1; clr_a = 1'b1; tick(3); clr_a = 1'b0;
      tick(1); ha = 1'b0; tick(10);
      check("R6", "edge during release dropped", digit_a, 4'd0);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      check("R6", "count resumes from zero", digit_a, 4'd1);

      // R7: independent clears
      configure(1'b0, 1'b0, 0, 0);
      for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, 1'b1, 1'b0);
      clr_a = 1'b1; #1;
      check("R6", "clear A immediate", digit_a, 4'd0);
      check("R7", "B kept on clear A", digit_b, 4'd3);
      tick(3); clr_a = 1'b0; tick(6);
      pulse(1'b1, 1'b0, 1'b0, 1'b0);
      clr_a = 1'b1; clr_b = 1'b1; #1;
      check("R7", "both clears A", digit_a, 4'd0);
      check("R7", "both clears B", digit_b, 4'd0);
      tick(3); clr_a = 1'b0; clr_b = 1'b0; tick(6);

      // R8: clearing A with carry high advances B
      configure(1'b0, 1'b0, 1, 0);
      for (int k = 0; k < 8; k++) pulse(1'b1, 1'b0, 1'b0, 1'b0);
      clr_a = 1'b1; tick(3); clr_a = 1'b0; tick(8);
      check("R8", "clear-induced carry fall", digit_b, 4'd1);

      // R10: every ratio
      ratio_run(1'b0, 1'b0, 0, 0, 1'b0, 0, 2);
      ratio_run(1'b0, 1'b0, 2, 0, 1'b1, 0, 4);
      ratio_run(1'b1, 1'b0, 0, 0, 1'b0, 3, 5);
      ratio_run(1'b0, 1'b0, 0, 0, 1'b0, 3, 10);
      ratio_run(1'b0, 1'b1, 2, 0, 1'b1, 0, 20);
      ratio_run(1'b1, 1'b1, 2, 3, 1'b1, 3, 25);
      ratio_run(1'b1, 1'b1, 2, 3, 1'b1, 0, 50);
      ratio_run(1'b0, 1'b0, 1, 0, 1'b1, 3, 100);

      // Random traffic against the stepping model (R2 R3 R4 R5 R7 R8)
      for (int r = 0; r < 16; r++) begin
         int steps;
         configure(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 3), int'($urandom % 4));
         steps = 20 + int'($urandom % 40);
         for (int s = 0; s < steps; s++) begin
            logic pa, ia, pb, ib, bfall;
            if ($urandom % 12 == 0) begin
               int which;
               which = int'($urandom % 3);
               if (which != 1) clr_a = 1'b1;
               if (which != 0) clr_b = 1'b1;
               #1;
               if (which == 0 && route != 0) begin
                  if (route == 1 ? fin(oa, ma) : ma[lbit]) mb = step(ob, mb);
               end
               if (which != 1) begin
                  ma = 4'd0;
                  check("R6", "random clear A", digit_a, 4'd0);
               end
               if (which != 0) begin
                  mb = 4'd0;
                  check("R6", "random clear B", digit_b, 4'd0);
               end
               tick(3); clr_a = 1'b0; clr_b = 1'b0; tick(8);
            end
            pa = ($urandom % 4) != 0;
            ia = 1'($urandom % 2);
            pb = 1'($urandom % 2);
            ib = 1'($urandom % 2);
            pulse(oa ? ia : pa, oa ? pa : ia, ob ? ib : pb, ob ? pb : ib);
            old_a = ma;
            if (pa) ma = step(oa, ma);
            case (route)
               0:       bfall = pb;
               1:       bfall = fin(oa, old_a) && !fin(oa, ma);
               default: bfall = old_a[lbit] && !ma[lbit];
            endcase
            if (bfall) mb = step(ob, mb);
            // unused pin toggles ride along: R5
            check(oa ? "R4" : "R3", "random digit A", digit_a, ma);
            check(route == 0 ? (ob ? "R4" : "R3") : "R8", "random digit B", digit_b, mb);
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule